// File: doc/BRIEF.md
# Cursor and Display Skew Delay Unit

This block sits next to a video timing chain and produces two signals per character time: a cursor marker and a display-enable. The cursor is raised when the character address from the timing chain equals a programmed cursor address and the current scanline within the character row falls inside a programmed band. The cursor can also blink at one of two rates, counted in frames. Before either signal leaves the block, it passes through its own programmable delay of zero, one or two character times. This lets the signals line up with downstream pixel pipelines of different depths.

One clock edge is one character time. Software programs five byte-wide registers through a simple write port, addressed by register index. A delay code of 3 holds its output low. Writing all ones to both delay fields therefore blanks the screen in one write. A later write that restores the display-enable delay code unblanks it again.

Top module: `crsr_skew_unit`

## Requirements
- R1: The raw cursor needs `mem_addr` to equal the 14-bit cursor address. Bits 13:8 of that address come from register 14 bits 5:0, and bits 7:0 come from register 15.
- R2: The raw cursor needs `row_line` to satisfy start <= row_line <= end. The start line is register 10 bits 4:0 and the end line is register 11 bits 4:0, so start 0 with end equal to the row's last line covers every scanline of the cell.
- R3: Register 10 bits 6:5 select the blink mode. Code 00 shows the cursor steadily, code 01 hides it, code 10 uses a 16-frame blink and code 11 uses a 32-frame blink.
- R4: A 5-bit frame counter advances by one on each clock edge that sees `frame_pulse` high, and wraps at 32. In mode 10 the cursor is visible while counter bit 3 is 0. In mode 11 it is visible while counter bit 4 is 0.
- R5: Register 8 bits 7:6 set the cursor delay. Code 0 routes the raw cursor straight out, code 1 delays it by one character time and code 2 delays it by two.
- R6: Register 8 bits 5:4 set the display-enable delay in the same way, applied to `disp_raw`.
- R7: Delay code 3 forces its output low. Writing 0xF0 to register 8 drives both outputs low. Writing 0xC0 lets the display-enable follow `disp_raw` with no delay while the cursor stays low.
- R8: A new delay code is used in the character time right after the write. The delay stages keep shifting whatever code is selected, so a switch to a delayed tap shows the true history of the signal.
- R9: A new cursor address or scanline band is compared from the character time right after the write.
- R10: After reset all registers and the frame counter are zero and the delay stages are clear.
- R11: A write to any index other than 8, 10, 11, 14 or 15 changes nothing that can be seen at the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock, one edge per character time |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 5 | Register index for the write |
| cfg_wdata | input | 8 | Register write data |
| mem_addr | input | AW (14) | Current character address from the timing chain |
| row_line | input | LW (5) | Scanline count within the character row |
| disp_raw | input | 1 | Undelayed display-enable from the timing chain |
| frame_pulse | input | 1 | One-cycle pulse per frame |
| cur_out | output | 1 | Delayed cursor |
| de_out | output | 1 | Delayed display-enable |

## Verification
The bench builds the block with its default values: a 14-bit address, a 5-bit scanline count, two delay stages and a 5-bit frame counter. With a 5-bit scanline count, every scanline value from 0 to 31 can be swept against several start and end bands. With a 5-bit frame counter, a run of about seventy frame pulses covers both blink periods and the counter wrap. All sixteen pairs of cursor and display delay codes are swept. The delay code is changed while traffic is running, so the first character after each switch is checked against the history the bench has recorded.

// File: rtl/crsr_pkg.sv
package crsr_pkg;

    localparam int REG_SKEW    = 8;
    localparam int REG_CSTART  = 10;
    localparam int REG_CEND    = 11;
    localparam int REG_CADDR_H = 14;
    localparam int REG_CADDR_L = 15;

    typedef enum logic [1:0] {
        BLINK_STEADY = 2'b00,
        BLINK_HIDDEN = 2'b01,
        BLINK_SLOW   = 2'b10,
        BLINK_FAST   = 2'b11
    } blink_mode_e;

    typedef enum logic [1:0] {
        SKEW_NONE  = 2'b00,
        SKEW_ONE   = 2'b01,
        SKEW_TWO   = 2'b10,
        SKEW_BLANK = 2'b11
    } skew_code_e;

endpackage

// File: rtl/crsr_regs.sv
module crsr_regs
    import crsr_pkg::*;
#(
    parameter int AW = 14,
    parameter int LW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [4:0]        cfg_idx,
    input  logic [7:0]        cfg_wdata,
    output skew_code_e        cur_skew,
    output skew_code_e        de_skew,
    output blink_mode_e       blink_mode,
    output logic [LW-1:0]     line_first,
    output logic [LW-1:0]     line_last,
    output logic [AW-1:0]     cur_addr
);
    localparam int HI_W = AW - 8;

    logic unused_wdata;
    assign unused_wdata = ^{cfg_wdata[7], cfg_wdata[3:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_skew   <= SKEW_NONE;
            de_skew    <= SKEW_NONE;
            blink_mode <= BLINK_STEADY;
            line_first <= '0;
            line_last  <= '0;
            cur_addr   <= '0;
        end else if (cfg_we) begin
            case (int'(cfg_idx))
                REG_SKEW: begin
                    cur_skew <= skew_code_e'(cfg_wdata[7:6]);
                    de_skew  <= skew_code_e'(cfg_wdata[5:4]);
                end
                REG_CSTART: begin
                    blink_mode <= blink_mode_e'(cfg_wdata[6:5]);
                    line_first <= cfg_wdata[LW-1:0];
                end
                REG_CEND:    line_last          <= cfg_wdata[LW-1:0];
                REG_CADDR_H: cur_addr[AW-1:8]   <= cfg_wdata[HI_W-1:0];
                REG_CADDR_L: cur_addr[7:0]      <= cfg_wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/crsr_match.sv
module crsr_match
    import crsr_pkg::*;
#(
    parameter int AW  = 14,
    parameter int LW  = 5,
    parameter int FCW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_pulse,
    input  logic [AW-1:0]  mem_addr,
    input  logic [LW-1:0]  row_line,
    input  logic [AW-1:0]  cur_addr,
    input  logic [LW-1:0]  line_first,
    input  logic [LW-1:0]  line_last,
    input  blink_mode_e    blink_mode,
    output logic           cur_raw,
    output logic [FCW-1:0] frame_cnt
);
    localparam int SLOW_BIT = 3;
    localparam int FAST_BIT = 4;

    logic blink_vis;
    logic in_band;
    logic addr_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           frame_cnt <= '0;
        else if (frame_pulse) frame_cnt <= frame_cnt + 1'b1;
    end

    always_comb begin
        unique case (blink_mode)
            BLINK_STEADY: blink_vis = 1'b1;
            BLINK_HIDDEN: blink_vis = 1'b0;
            BLINK_SLOW:   blink_vis = ~frame_cnt[SLOW_BIT];
            BLINK_FAST:   blink_vis = ~frame_cnt[FAST_BIT];
        endcase
    end

    assign in_band  = (row_line >= line_first) && (row_line <= line_last);
    assign addr_hit = (mem_addr == cur_addr);
    assign cur_raw  = blink_vis & in_band & addr_hit;
endmodule

// File: rtl/skew_line.sv
module skew_line
    import crsr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sig_in,
    input  skew_code_e code,
    output logic       sig_out
);
    logic [STAGES-1:0] q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '0;
                else        q <= sig_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '0;
                else        q <= {q[STAGES-2:0], sig_in};
            end
        end
    endgenerate

    always_comb begin
        sig_out = 1'b0;
        if (code == SKEW_NONE) begin
            sig_out = sig_in;
        end else if (code != SKEW_BLANK) begin
            for (int k = 1; k <= STAGES; k++) begin
                if (int'(code) == k) sig_out = q[k-1];
            end
        end
    end
endmodule

// File: rtl/crsr_skew_unit.sv
module crsr_skew_unit
    import crsr_pkg::*;
#(
    parameter int AW     = 14,
    parameter int LW     = 5,
    parameter int FCW    = 5,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [4:0]    cfg_idx,
    input  logic [7:0]    cfg_wdata,
    input  logic [AW-1:0] mem_addr,
    input  logic [LW-1:0] row_line,
    input  logic          disp_raw,
    input  logic          frame_pulse,
    output logic          cur_out,
    output logic          de_out
);
    skew_code_e     cur_code;
    skew_code_e     de_code;
    blink_mode_e    blink_mode;
    logic [LW-1:0]  line_first;
    logic [LW-1:0]  line_last;
    logic [AW-1:0]  cur_addr;
    logic           cur_raw;
    logic [FCW-1:0] frame_cnt;

    crsr_regs #(.AW(AW), .LW(LW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_idx    (cfg_idx),
        .cfg_wdata  (cfg_wdata),
        .cur_skew   (cur_code),
        .de_skew    (de_code),
        .blink_mode (blink_mode),
        .line_first (line_first),
        .line_last  (line_last),
        .cur_addr   (cur_addr)
    );

    crsr_match #(.AW(AW), .LW(LW), .FCW(FCW)) u_match (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_pulse (frame_pulse),
        .mem_addr    (mem_addr),
        .row_line    (row_line),
        .cur_addr    (cur_addr),
        .line_first  (line_first),
        .line_last   (line_last),
        .blink_mode  (blink_mode),
        .cur_raw     (cur_raw),
        .frame_cnt   (frame_cnt)
    );

    skew_line #(.STAGES(STAGES)) u_cur_skew (
        .clk     (clk),
        .rst_n   (rst_n),
        .sig_in  (cur_raw),
        .code    (cur_code),
        .sig_out (cur_out)
    );

    skew_line #(.STAGES(STAGES)) u_de_skew (
        .clk     (clk),
        .rst_n   (rst_n),
        .sig_in  (disp_raw),
        .code    (de_code),
        .sig_out (de_out)
    );
endmodule

// File: rtl/crsr_skew_chk.sv
module crsr_skew_chk
    import crsr_pkg::*;
#(
    parameter int AW  = 14,
    parameter int FCW = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic [AW-1:0]  mem_addr,
    input logic [AW-1:0]  cur_addr,
    input logic           disp_raw,
    input logic           frame_pulse,
    input logic           cur_raw,
    input logic           cur_out,
    input logic           de_out,
    input skew_code_e     cur_code,
    input skew_code_e     de_code,
    input logic [FCW-1:0] frame_cnt
);
    logic [1:0] warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          warm <= 2'd0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    a_r1_addr_match: assert property (@(posedge clk) disable iff (!rst_n)
        cur_raw |-> (mem_addr == cur_addr));

    a_r4_frame_step: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |=> (frame_cnt == FCW'($past(frame_cnt) + 1'b1)));

    a_r5_cur_two: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_code == SKEW_TWO && warm >= 2'd2) |-> (cur_out == $past(cur_raw, 2)));

    a_r6_de_one: assert property (@(posedge clk) disable iff (!rst_n)
        (de_code == SKEW_ONE && warm >= 2'd1) |-> (de_out == $past(disp_raw)));

    a_r7_cur_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_code == SKEW_BLANK) |-> !cur_out);

    a_r7_de_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (de_code == SKEW_BLANK) |-> !de_out);
endmodule

bind crsr_skew_unit crsr_skew_chk #(.AW(AW), .FCW(FCW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_addr    (mem_addr),
    .cur_addr    (cur_addr),
    .disp_raw    (disp_raw),
    .frame_pulse (frame_pulse),
    .cur_raw     (cur_raw),
    .cur_out     (cur_out),
    .de_out      (de_out),
    .cur_code    (cur_code),
    .de_code     (de_code),
    .frame_cnt   (frame_cnt)
);

// File: tb/crsr_skew_unit_tb.sv
module crsr_skew_unit_tb;
    localparam int AW = 14;
    localparam int LW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [4:0]    cfg_idx = '0;
    logic [7:0]    cfg_wdata = '0;
    logic [AW-1:0] mem_addr = 14'd1;
    logic [LW-1:0] row_line = '0;
    logic          disp_raw = 1'b0;
    logic          frame_pulse = 1'b0;
    logic          cur_out;
    logic          de_out;

    int checks = 0;
    int errors = 0;

    // bench shadow of the programmed state
    logic [1:0]    sh_cur = 0, sh_de = 0, sh_mode = 0;
    logic [LW-1:0] sh_start = 0, sh_end = 0;
    logic [AW-1:0] sh_ca = 0;
    logic [4:0]    fcnt = 0;
    logic hc0 = 0, hc1 = 0, hd0 = 0, hd1 = 0;

    always #2.5 clk = ~clk;

    crsr_skew_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .mem_addr(mem_addr), .row_line(row_line),
        .disp_raw(disp_raw), .frame_pulse(frame_pulse),
        .cur_out(cur_out), .de_out(de_out)
    );

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: run hung, act=timeout exp=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: act=%0b exp=%0b", tag, $time, act, exp);
        end
    endtask

    function automatic logic exp_raw(input logic [AW-1:0] a, input logic [LW-1:0] l);
        logic vis;
        case (sh_mode)
            2'b00: vis = 1'b1;
            2'b01: vis = 1'b0;
            2'b10: vis = ~fcnt[3];
            default: vis = ~fcnt[4];
        endcase
        return vis && (a == sh_ca) && (l >= sh_start) && (l <= sh_end);
    endfunction

    function automatic logic pick(input logic [1:0] c, input logic now,
                                  input logic d1, input logic d2);
        case (c)
            2'd0: return now;
            2'd1: return d1;
            2'd2: return d2;
            default: return 1'b0;
        endcase
    endfunction

    // one character time; inputs already driven after a falling edge
    task automatic cyc(input bit do_chk, input string tag);
        logic rc;
        #1;
        rc = exp_raw(mem_addr, row_line);
        if (do_chk) begin
            chk({tag, " cursor"}, cur_out, pick(sh_cur, rc, hc0, hc1));
            chk({tag, " enable"}, de_out, pick(sh_de, disp_raw, hd0, hd1));
        end
        @(posedge clk);
        hc1 = hc0; hc0 = rc; hd1 = hd0; hd0 = disp_raw;
        if (frame_pulse) fcnt = fcnt + 5'd1;
        if (cfg_we) begin
            case (int'(cfg_idx))
                8:  begin sh_cur = cfg_wdata[7:6]; sh_de = cfg_wdata[5:4]; end
                10: begin sh_mode = cfg_wdata[6:5]; sh_start = cfg_wdata[4:0]; end
                11: sh_end = cfg_wdata[4:0];
                14: sh_ca[13:8] = cfg_wdata[5:0];
                15: sh_ca[7:0] = cfg_wdata;
                default: ;
            endcase
        end
        @(negedge clk);
    endtask

    task automatic wr(input int idx, input logic [7:0] d, input bit do_chk, input string tag);
        cfg_we = 1'b1; cfg_idx = 5'(idx); cfg_wdata = d;
        cyc(do_chk, tag);
        cfg_we = 1'b0;
    endtask

    initial begin
        // R10: reset state
        @(negedge clk);
        chk("R10 reset cursor", cur_out, 1'b0);
        chk("R10 reset enable", de_out, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        mem_addr = 14'd0; row_line = 5'd0;
        cyc(1, "R10 zeroed address match");
        mem_addr = 14'd1; row_line = 5'd1;
        cyc(1, "R10 band zero");

        wr(10, 8'h02, 0, "");
        wr(11, 8'h05, 0, "");
        wr(14, 8'h02, 0, "");
        wr(15, 8'hA5, 0, "");

        // R5 R6 R7 R8: every pair of delay codes, codes switched under traffic
        for (int cc = 0; cc < 4; cc++) begin
            for (int dc = 0; dc < 4; dc++) begin
                wr(8, {2'(cc), 2'(dc), 4'h0}, 1, "R8 switch");
                for (int i = 0; i < 40; i++) begin
                    mem_addr = ((i % 3) == 0) ? sh_ca : (sh_ca ^ 14'(1 << (i % 14)));
                    row_line = 5'(i % 8);
                    disp_raw = (((i * 3) % 7) < 4);
                    cyc(1, "R1 R5 R6 R7 skew");
                end
            end
        end

        // R2: full scanline sweep over several bands
        wr(8, 8'h00, 0, "");
        mem_addr = sh_ca;
        for (int s = 0; s < 3; s++) begin
            for (int e = 0; e < 4; e++) begin
                wr(10, 8'((s == 0) ? 0 : (s == 1) ? 3 : 7), 0, "");
                wr(11, 8'((e == 0) ? 0 : (e == 1) ? 5 : (e == 2) ? 7 : 31), 0, "");
                for (int l = 0; l < 32; l++) begin
                    row_line = 5'(l);
                    cyc(1, "R2 band");
                end
            end
        end

        // R3 R4: blink modes across frame counter wrap
        row_line = 5'd3;
        wr(11, 8'h07, 0, "");
        for (int m = 0; m < 4; m++) begin
            wr(10, {1'b0, 2'(m), 5'd0}, 1, "R3 mode");
            for (int f = 0; f < 70; f++) begin
                cyc(1, "R3 R4 blink");
                frame_pulse = 1'b1;
                cyc(1, "R4 frame pulse");
                frame_pulse = 1'b0;
            end
        end
        wr(10, 8'h00, 0, "");

        // R9: cursor address rewritten mid-display
        wr(15, 8'h3C, 0, "");
        mem_addr = sh_ca;
        cyc(1, "R9 new address hit");
        mem_addr = {sh_ca[13:8], 8'hA5};
        cyc(1, "R9 old address miss");
        wr(14, 8'h11, 0, "");
        mem_addr = sh_ca;
        cyc(1, "R9 new high byte hit");

        // R11: writes to unused indices change nothing
        wr(8, 8'h50, 0, "");
        for (int k = 0; k < 4; k++) begin
            wr((k == 0) ? 9 : (k == 1) ? 12 : (k == 2) ? 13 : 16, 8'hFF, 1, "R11 ignored write");
            disp_raw = (k % 2) == 0;
            mem_addr = sh_ca;
            cyc(1, "R11 after ignored write");
            mem_addr = ~sh_ca;
            cyc(1, "R11 after ignored write");
        end

        // R7: 0xF0 blanks, 0xC0 unblanks the display only
        mem_addr = sh_ca; disp_raw = 1'b1;
        wr(8, 8'hF0, 0, "");
        for (int i = 0; i < 4; i++) begin
            disp_raw = (i % 2) == 0;
            cyc(1, "R7 blank F0");
        end
        wr(8, 8'hC0, 0, "");
        for (int i = 0; i < 4; i++) begin
            disp_raw = (i % 2) == 1;
            cyc(1, "R7 unblank C0");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule